// File: doc/BRIEF.md
# Parallel NOR Flash Identifier Sequencer

This block identifies the flash device sitting on a simple parallel NOR bus. When it sees a start pulse it runs a fixed command script over the bus. First it writes two unlock cycles and the identifier-mode command. Next it reads the manufacturer code and the device code, and it then writes a reset so the array returns to normal read mode. When the whole script has finished it presents the results and raises a one-cycle done pulse.

Some flash parts use an escape value in the device code word. When the first device-code read returns that value, the block adds two more reads and builds a three-byte identifier. Several identical chips can sit side by side on one wide bus, one chip per lane. The block writes every command into every lane, and it takes the identifier only from the least significant lane.

Each bus access is one transaction with a request/acknowledge handshake. The request and its address, data and direction stay fixed until the acknowledge arrives.

Top module: `nor_id_reader`

## Requirements
- R1: After reset, and after a reset applied in the middle of a run, `bus_req_o`, `busy_o` and `done_o` are all low.
- R2: A run opens with three writes in this order: 0xAA at word address 0x555, 0x55 at 0x2AA, then 0x90 at 0x555. Each command byte is placed in bits [7:0] of every device lane (lane width = BUS_W/DEV_CNT), and the other bits are zero. With the default 32-bit bus and two devices, the words are 0x00AA00AA, 0x00550055 and 0x00900090.
- R3: The fourth access is a read at word address 0x000. Bits [7:0] of the returned word appear on `mfr_o`.
- R4: The fifth access is a read at word address 0x001. The returned word is masked to the lowest device lane, so data in the upper lanes has no effect on the result.
- R5: If the masked device code equals 0x007E, two more reads follow, at 0x00E and then at 0x00F. `id_o` becomes {0x7E, byte[7:0] of the 0x00E read, byte[7:0] of the 0x00F read}.
- R6: If the masked device code is any other value, no extra reads are made, and `id_o` is bits [23:0] of the masked code.
- R7: The final access of every run is a write of 0xF0, replicated across the lanes as in R2, at word address 0x555. Nothing else is written after it.
- R8: While `bus_req_o` is high and `bus_ack_i` is low, `bus_addr_o`, `bus_we_o` and `bus_wdata_o` hold their values. No new access starts until the current one is acknowledged. Any acknowledge latency must be handled.
- R9: A start pulse that arrives while `busy_o` is high is ignored. The run in progress keeps its access sequence, and only one done pulse results.
- R10: `done_o` goes high for exactly one cycle, in the cycle after the reset write is acknowledged. In that same cycle `busy_o` is low and `id_o` and `mfr_o` hold the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse for one identification run |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse when a run completes |
| id_o | output | 24 | Device identifier |
| mfr_o | output | 8 | Manufacturer code |
| bus_req_o | output | 1 | Access request, held until acknowledged |
| bus_we_o | output | 1 | 1 = write access, 0 = read access |
| bus_addr_o | output | ADDR_W | Word address |
| bus_wdata_o | output | BUS_W | Write data |
| bus_rdata_i | input | BUS_W | Read data, valid when acknowledged |
| bus_ack_i | input | 1 | Access acknowledge |

## Verification
The bench goes after the escape branch from both sides:
- an upper-lane escape value hidden behind a non-escape low lane, which catches a design that forgets to mask;
- a low-lane escape with garbage in the upper lane, which catches a design that compares the full word;
- a near miss (0x017E), which catches a design that compares only the low byte.

A design that got any of these wrong would report the wrong identifier and make the wrong number of accesses.

Acknowledge latencies from zero to three cycles expose a sequencer that advances without waiting for the acknowledge; such a design would skip or duplicate writes. A second start pulse in mid-run, and a reset in mid-run, catch a controller that restarts its script or keeps requesting after reset.

// File: rtl/nor_id_pkg.sv
// Package: shared step encoding, command bytes and word offsets for the
// NOR identifier sequencer. Assumes word addressing on the flash bus.
package nor_id_pkg;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_UNLOCK1 = 4'd1,
        ST_UNLOCK2 = 4'd2,
        ST_IDMODE  = 4'd3,
        ST_RD_MFR  = 4'd4,
        ST_RD_DEV  = 4'd5,
        ST_RD_EXT1 = 4'd6,
        ST_RD_EXT2 = 4'd7,
        ST_EXIT    = 4'd8
    } nor_step_e;

    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_IDMODE   = 8'h90;
    localparam logic [7:0] CMD_EXIT     = 8'hF0;

    localparam logic [11:0] OFS_CMD_A = 12'h555;
    localparam logic [11:0] OFS_CMD_B = 12'h2AA;
    localparam logic [11:0] OFS_MFR   = 12'h000;
    localparam logic [11:0] OFS_DEV   = 12'h001;
    localparam logic [11:0] OFS_EXT1  = 12'h00E;
    localparam logic [11:0] OFS_EXT2  = 12'h00F;

    localparam logic [15:0] DEV_ESCAPE = 16'h007E;

endpackage

// File: rtl/nor_id_bus_port.sv
// Bus port: turns a one-cycle go request into a held req/ack transaction.
// Assumes the caller issues go only while no access is outstanding.
module nor_id_bus_port #(
    parameter int ADDR_W = 12,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic              fin_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [BUS_W-1:0]  bus_wdata_o,
    input  logic              bus_ack_i
);

    // Access completes in the cycle the acknowledge meets the request.
    assign fin_o = bus_req_o & bus_ack_i;

    // Hold the request and its payload until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req_o   <= 1'b0;
            bus_we_o    <= 1'b0;
            bus_addr_o  <= '0;
            bus_wdata_o <= '0;
        end else if (fin_o) begin
            bus_req_o   <= 1'b0;
        end else if (go_i && !bus_req_o) begin
            bus_req_o   <= 1'b1;
            bus_we_o    <= we_i;
            bus_addr_o  <= addr_i;
            bus_wdata_o <= wdata_i;
        end
    end

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o)
            && $stable(bus_we_o) && $stable(bus_wdata_o));

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> !go_i);

endmodule

// File: rtl/nor_id_seq.sv
// Sequencer: walks the unlock / identify / exit script one access at a
// time, branching to the extended reads when the device code escapes.
// Assumes fin_i pulses once per access issued through go_o.
module nor_id_seq
    import nor_id_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int BUS_W   = 32,
    parameter int DEV_CNT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              fin_i,
    input  logic              escape_i,
    output logic              go_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BUS_W-1:0]  wdata_o,
    output logic              cap_mfr_o,
    output logic              cap_dev_o,
    output logic              cap_ext1_o,
    output logic              cap_ext2_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int LANE_W = BUS_W / DEV_CNT;

    nor_step_e step_q;
    logic      pend_q;

    // Place a command byte in the low byte of every device lane.
    function automatic logic [BUS_W-1:0] lane_rep(input logic [7:0] b);
        logic [BUS_W-1:0] w;
        w = '0;
        for (int i = 0; i < DEV_CNT; i++) w[i*LANE_W +: 8] = b;
        return w;
    endfunction

    // Decode the current step into the access it performs.
    always_comb begin
        we_o    = 1'b0;
        addr_o  = '0;
        wdata_o = '0;
        unique case (step_q)
            ST_UNLOCK1: begin we_o = 1'b1; addr_o = ADDR_W'(OFS_CMD_A); wdata_o = lane_rep(CMD_UNLOCK_A); end
            ST_UNLOCK2: begin we_o = 1'b1; addr_o = ADDR_W'(OFS_CMD_B); wdata_o = lane_rep(CMD_UNLOCK_B); end
            ST_IDMODE:  begin we_o = 1'b1; addr_o = ADDR_W'(OFS_CMD_A); wdata_o = lane_rep(CMD_IDMODE);   end
            ST_RD_MFR:  addr_o = ADDR_W'(OFS_MFR);
            ST_RD_DEV:  addr_o = ADDR_W'(OFS_DEV);
            ST_RD_EXT1: addr_o = ADDR_W'(OFS_EXT1);
            ST_RD_EXT2: addr_o = ADDR_W'(OFS_EXT2);
            ST_EXIT:    begin we_o = 1'b1; addr_o = ADDR_W'(OFS_CMD_A); wdata_o = lane_rep(CMD_EXIT); end
            default:    ;
        endcase
    end

    assign busy_o     = (step_q != ST_IDLE);
    assign go_o       = busy_o && !pend_q;
    assign cap_mfr_o  = fin_i && (step_q == ST_RD_MFR);
    assign cap_dev_o  = fin_i && (step_q == ST_RD_DEV);
    assign cap_ext1_o = fin_i && (step_q == ST_RD_EXT1);
    assign cap_ext2_o = fin_i && (step_q == ST_RD_EXT2);

    // Advance the script on each completed access; pulse done at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_IDLE;
            pend_q <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (fin_i)     pend_q <= 1'b0;
            else if (go_o) pend_q <= 1'b1;
            if (step_q == ST_IDLE) begin
                if (start_i) step_q <= ST_UNLOCK1;
            end else if (fin_i) begin
                unique case (step_q)
                    ST_UNLOCK1: step_q <= ST_UNLOCK2;
                    ST_UNLOCK2: step_q <= ST_IDMODE;
                    ST_IDMODE:  step_q <= ST_RD_MFR;
                    ST_RD_MFR:  step_q <= ST_RD_DEV;
                    ST_RD_DEV:  step_q <= escape_i ? ST_RD_EXT1 : ST_EXIT;
                    ST_RD_EXT1: step_q <= ST_RD_EXT2;
                    ST_RD_EXT2: step_q <= ST_EXIT;
                    ST_EXIT: begin
                        step_q <= ST_IDLE;
                        done_o <= 1'b1;
                    end
                    default:    step_q <= ST_IDLE;
                endcase
            end
        end
    end

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_exit_then_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fin_i && (step_q == ST_EXIT) |=> done_o && !busy_o);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i && !fin_i |=> $stable(step_q));

endmodule

// File: rtl/nor_id_assemble.sv
// Assembler: masks the device code to the lowest lane, flags the escape
// value and builds the 24-bit identifier and manufacturer byte.
// Assumes BUS_W is at most 32 and divisible by DEV_CNT.
module nor_id_assemble
    import nor_id_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int DEV_CNT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] rdata_i,
    input  logic             cap_mfr_i,
    input  logic             cap_dev_i,
    input  logic             cap_ext1_i,
    input  logic             cap_ext2_i,
    output logic             escape_o,
    output logic [23:0]      id_o,
    output logic [7:0]       mfr_o
);

    localparam int LANE_W = BUS_W / DEV_CNT;

    logic [BUS_W-1:0] lane_mask;
    logic [BUS_W-1:0] masked;
    logic             esc_q;

    // Build the lowest-lane mask; a single device keeps the full word.
    generate
        if (LANE_W >= BUS_W) begin : g_full
            assign lane_mask = '1;
        end else begin : g_part
            assign lane_mask = {{(BUS_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
        end
    endgenerate

    assign masked   = rdata_i & lane_mask;
    assign escape_o = (masked == BUS_W'(DEV_ESCAPE));

    // Capture each read into its field of the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_o  <= '0;
            mfr_o <= '0;
            esc_q <= 1'b0;
        end else begin
            if (cap_mfr_i) mfr_o <= rdata_i[7:0];
            if (cap_dev_i) begin
                esc_q <= escape_o;
                id_o  <= escape_o ? {DEV_ESCAPE[7:0], 16'h0000} : 24'(masked);
            end
            if (cap_ext1_i) id_o[15:8] <= rdata_i[7:0];
            if (cap_ext2_i) id_o[7:0]  <= rdata_i[7:0];
        end
    end

    assert_ext_after_escape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ext1_i || cap_ext2_i) |-> esc_q);

    assert_ext_prefix_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ext2_i |=> id_o[23:16] == DEV_ESCAPE[7:0]);

endmodule

// File: rtl/nor_id_reader.sv
// Top: NOR flash identifier reader. Connects the sequencer, bus port and
// assembler. Assumes one chip per lane and at most a 32-bit bus.
module nor_id_reader #(
    parameter int ADDR_W  = 12,
    parameter int BUS_W   = 32,
    parameter int DEV_CNT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [23:0]       id_o,
    output logic [7:0]        mfr_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [BUS_W-1:0]  bus_wdata_o,
    input  logic [BUS_W-1:0]  bus_rdata_i,
    input  logic              bus_ack_i
);

    logic              go, we, fin, escape;
    logic [ADDR_W-1:0] addr;
    logic [BUS_W-1:0]  wdata;
    logic              cap_mfr, cap_dev, cap_ext1, cap_ext2;

    nor_id_seq #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .DEV_CNT(DEV_CNT)) seq_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fin_i(fin),
        .escape_i(escape), .go_o(go), .we_o(we), .addr_o(addr),
        .wdata_o(wdata), .cap_mfr_o(cap_mfr), .cap_dev_o(cap_dev),
        .cap_ext1_o(cap_ext1), .cap_ext2_o(cap_ext2),
        .busy_o(busy_o), .done_o(done_o)
    );

    nor_id_bus_port #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) port_i (
        .clk(clk), .rst_n(rst_n), .go_i(go), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .fin_o(fin), .bus_req_o(bus_req_o),
        .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i)
    );

    nor_id_assemble #(.BUS_W(BUS_W), .DEV_CNT(DEV_CNT)) asm_i (
        .clk(clk), .rst_n(rst_n), .rdata_i(bus_rdata_i),
        .cap_mfr_i(cap_mfr), .cap_dev_i(cap_dev), .cap_ext1_i(cap_ext1),
        .cap_ext2_i(cap_ext2), .escape_o(escape), .id_o(id_o), .mfr_o(mfr_o)
    );

endmodule

// File: tb/nor_id_reader_tb_top.sv
`timescale 1ns/1ps
module nor_id_reader_tb_top;

    typedef struct packed {
        logic [7:0]  lat;
        logic [31:0] mfr_w;
        logic [31:0] dev_w;
        logic [31:0] e1_w;
        logic [31:0] e2_w;
        logic [23:0] exp_id;
        logic [7:0]  exp_mfr;
        logic        exp_ext;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{8'd0, 32'h0000_0001, 32'h0000_22A7, 32'h0, 32'h0, 24'h0022A7, 8'h01, 1'b0},
        '{8'd2, 32'hFF00_00C2, 32'hFFFF_007E, 32'h0000_2210, 32'h0000_0001, 24'h7E1001, 8'hC2, 1'b1},
        '{8'd1, 32'h0000_0020, 32'h0001_007E, 32'h5500_000C, 32'h0000_0000, 24'h7E0C00, 8'h20, 1'b1},
        '{8'd3, 32'h0000_0089, 32'h0000_017E, 32'h0, 32'h0, 24'h00017E, 8'h89, 1'b0},
        '{8'd0, 32'h0000_0004, 32'h007E_0000, 32'h0, 32'h0, 24'h000000, 8'h04, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, req, we, ack;
    logic [23:0] id;
    logic [7:0]  mfr;
    logic [11:0] addr;
    logic [31:0] wdata, rdata;

    int checks = 0;
    int failures = 0;

    logic [7:0]  m_lat;
    logic [31:0] m_mfr, m_dev, m_e1, m_e2;
    int          m_cnt;
    logic        log_we   [16];
    logic [11:0] log_addr [16];
    logic [31:0] log_wd   [16];
    int          nlog;
    int          done_cnt;

    always #10 clk = ~clk;

    nor_id_reader dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy),
        .done_o(done), .id_o(id), .mfr_o(mfr), .bus_req_o(req),
        .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
        .bus_rdata_i(rdata), .bus_ack_i(ack)
    );

    // Flash model: acknowledges after m_lat idle cycles, logs each access.
    initial begin
        ack = 1'b0; rdata = '0; m_cnt = 0; nlog = 0; done_cnt = 0;
        m_lat = 0; m_mfr = 0; m_dev = 0; m_e1 = 0; m_e2 = 0;
        forever begin
            @(negedge clk);
            if (done) done_cnt++;
            if (!rst_n) begin
                ack = 1'b0; m_cnt = 0;
            end else if (ack) begin
                ack = 1'b0;
            end else if (req) begin
                if (m_cnt >= int'(m_lat)) begin
                    ack = 1'b1; m_cnt = 0;
                    case (addr)
                        12'h000: rdata = m_mfr;
                        12'h001: rdata = m_dev;
                        12'h00E: rdata = m_e1;
                        12'h00F: rdata = m_e2;
                        default: rdata = 32'hDEAD_BEEF;
                    endcase
                    if (nlog < 16) begin
                        log_we[nlog] = we; log_addr[nlog] = addr; log_wd[nlog] = wdata;
                    end
                    nlog++;
                end else begin
                    m_cnt++;
                end
            end
        end
    end

    task automatic chk(input string req_tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req_tag, what, act, exp);
        end
    endtask

    task automatic chk_acc(input string req_tag, input int idx, input logic exp_we,
                           input logic [11:0] exp_a, input logic [31:0] exp_d);
        chk(req_tag, $sformatf("access %0d dir", idx), 32'(log_we[idx]), 32'(exp_we));
        chk(req_tag, $sformatf("access %0d addr", idx), 32'(log_addr[idx]), 32'(exp_a));
        if (exp_we) chk(req_tag, $sformatf("access %0d data", idx), log_wd[idx], exp_d);
    endtask

    // One run: optional extra start pulse mid-run; waits for done.
    task automatic run(input vec_t v, input bit dup_start);
        int waited;
        m_lat = v.lat; m_mfr = v.mfr_w; m_dev = v.dev_w; m_e1 = v.e1_w; m_e2 = v.e2_w;
        nlog = 0; done_cnt = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (dup_start) begin
            repeat (4) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 400) begin
            @(negedge clk); waited++;
        end
        chk("R10", "busy low with done", 32'(busy), 32'd0);
        chk("R10", "id at done", 32'(id), 32'(v.exp_id));
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "req after reset", 32'(req), 32'd0);
        chk("R1", "busy after reset", 32'(busy), 32'd0);
        chk("R1", "done after reset", 32'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NVEC; k++) begin
            int last;
            run(VECS[k], 1'b0);
            last = VECS[k].exp_ext ? 7 : 5;
            chk("R2", "unlock/identify writes", 32'(nlog), 32'(last + 1));
            chk_acc("R2", 0, 1'b1, 12'h555, 32'h00AA_00AA);
            chk_acc("R2", 1, 1'b1, 12'h2AA, 32'h0055_0055);
            chk_acc("R2", 2, 1'b1, 12'h555, 32'h0090_0090);
            chk_acc("R3", 3, 1'b0, 12'h000, 32'h0);
            chk_acc("R4", 4, 1'b0, 12'h001, 32'h0);
            if (VECS[k].exp_ext) begin
                chk_acc("R5", 5, 1'b0, 12'h00E, 32'h0);
                chk_acc("R5", 6, 1'b0, 12'h00F, 32'h0);
                chk("R5", "extended id", 32'(id), 32'(VECS[k].exp_id));
            end else begin
                chk("R6", "plain id", 32'(id), 32'(VECS[k].exp_id));
            end
            chk_acc("R7", last, 1'b1, 12'h555, 32'h00F0_00F0);
            chk("R3", "manufacturer", 32'(mfr), 32'(VECS[k].exp_mfr));
            chk("R8", "latency run done count", 32'(done_cnt), 32'd1);
            chk("R10", "done width", 32'(done_cnt), 32'd1);
        end

        // R9: a second start while busy changes nothing.
        run(VECS[1], 1'b1);
        chk("R9", "access count with extra start", 32'(nlog), 32'd8);
        chk("R9", "single done", 32'(done_cnt), 32'd1);
        chk("R9", "id unchanged", 32'(id), 32'h7E1001);

        // R1: reset in the middle of a run.
        m_lat = 8'd3; nlog = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "req after mid-run reset", 32'(req), 32'd0);
        chk("R1", "busy after mid-run reset", 32'(busy), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        run(VECS[0], 1'b0);
        chk("R6", "run after mid-run reset", 32'(id), 32'h0022A7);
        chk("R7", "accesses after mid-run reset", 32'(nlog), 32'd6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R10 watchdog: actual=%h expected=%h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule